// File: doc/BRIEF.md
# DMA Channel Control Register Block

This block holds the control and status registers of a multi-channel DMA layer that moves network-style transmit and receive traffic. Software reaches it through a simple single-cycle register port: a request strobe, a write flag, a 10-bit register address and 32-bit write data. Read data comes back one cycle later with a valid strobe. The DMA engine reports events through per-bit set inputs. These inputs raise bits in the error and interrupt status registers, and software later clears those bits by writing ones to them.

The fixed registers sit at fixed addresses: configuration, error status, interrupt enable, and a pair of channel-active set/reset words per direction. There are also two interrupt status words per direction, one for end-of-buffer and one for descriptor errors. A window of descriptor table pointers sits next to them, one per transmit channel. Each receive channel has its own descriptor table pointer and its own buffer size register. The channel counts are elaboration parameters, so the size of each window follows the configuration.

Writing the configuration register with its top bit set acts as a soft reset of the fixed registers. The per-channel windows keep their contents through a soft reset.

Top module: `dma_chan_regs`

## Requirements
- R1: After rst_ni is released, the registers read as follows: configuration 0x180 reads 0x0007C000; addresses 0x181, 0x182, 0x184 to 0x187 and 0x190 to 0x193 read 0; every pointer and size register reads 0.
- R2: A configuration write to 0x180 stores the write data ANDed with 0x00FFC087.
- R3: A configuration write with bit 31 set returns 0x181, 0x182, 0x184 to 0x187 and 0x190 to 0x193 to 0 in the same cycle, and stores the masked value in configuration. Pointer and size registers keep their contents.
- R4: Addresses 0x181 (error), 0x186 (TX end-of-buffer), 0x187 (TX descriptor error), 0x192 (RX end-of-buffer) and 0x193 (RX descriptor error) are write-one-to-clear. A 1 on bit n of the matching set input (err_set_i, tx_eob_set_i, tx_derr_set_i, rx_eob_set_i, rx_derr_set_i) sets bit n at the next edge. If a set and a clear hit the same bit in the same cycle, the set wins.
- R5: The interrupt enable at 0x182 keeps only bits 4:0 of the written value.
- R6: TX active set 0x184 and TX active reset 0x185 keep bits 31:28. RX active set 0x190 and RX active reset 0x191 keep bits 31:30. Each is a plain stored register.
- R7: The TX descriptor pointer of channel i is at 0x1A0+i for i < TX_CH and stores all 32 bits.
- R8: The RX descriptor pointer of channel i is at 0x1C0+i and stores all 32 bits. The RX buffer size of channel i is at 0x1E0+i and keeps bits 7:0. Both apply for i < RX_CH.
- R9: An unmapped address reads 0, and a write to it changes no register. Addresses past a channel window's configured count and the gaps between fixed registers are unmapped.
- R10: A read request sampled at a rising edge returns its data on rdata_o with rvalid_o high after that edge. rvalid_o is low after any edge without a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 10 | Register address |
| wdata_i | input | 32 | Write data |
| err_set_i | input | 32 | Error status set bits |
| tx_eob_set_i | input | 32 | TX end-of-buffer status set bits |
| tx_derr_set_i | input | 32 | TX descriptor-error status set bits |
| rx_eob_set_i | input | 32 | RX end-of-buffer status set bits |
| rx_derr_set_i | input | 32 | RX descriptor-error status set bits |
| rdata_o | output | 32 | Read data, registered |
| rvalid_o | output | 1 | Read data valid |

## Verification
A write and a status set pulse both take effect at the rising edge that samples them. A following read therefore always sees the new value. Read data is due exactly one edge after the request: rvalid_o and rdata_o change at the edge that samples the read. The driver queues each expected word as it issues the read. The monitor checks rvalid_o at the falling edge after that, takes the oldest expected word from the queue and compares it. This keeps the comparison one cycle behind the request and clear of the active edge. The same-cycle set-versus-clear case is driven in one cycle so that both meet at a single edge.

// File: rtl/dmr_pkg.sv
package dmr_pkg;
  localparam int unsigned AW = 10;
  localparam int unsigned DW = 32;
  localparam int unsigned NUM_STAT = 5;
  localparam int unsigned SOFT_RST_BIT = 31;

  typedef logic [AW-1:0] addr_t;
  typedef logic [DW-1:0] word_t;

  typedef struct packed {
    logic  vld;
    logic  wr;
    addr_t addr;
    word_t wdata;
  } bus_req_t;

  localparam addr_t ADR_CFG     = 10'h180;
  localparam addr_t ADR_ERR     = 10'h181;
  localparam addr_t ADR_IEN     = 10'h182;
  localparam addr_t ADR_TX_SET  = 10'h184;
  localparam addr_t ADR_TX_RST  = 10'h185;
  localparam addr_t ADR_TX_EOB  = 10'h186;
  localparam addr_t ADR_TX_DERR = 10'h187;
  localparam addr_t ADR_RX_SET  = 10'h190;
  localparam addr_t ADR_RX_RST  = 10'h191;
  localparam addr_t ADR_RX_EOB  = 10'h192;
  localparam addr_t ADR_RX_DERR = 10'h193;
  localparam addr_t ADR_TX_PTR  = 10'h1A0;
  localparam addr_t ADR_RX_PTR  = 10'h1C0;
  localparam addr_t ADR_RX_SIZE = 10'h1E0;

  localparam word_t CFG_INIT    = 32'h0007_C000;
  localparam word_t CFG_KEEP    = 32'h00FF_C087;
  localparam word_t IEN_KEEP    = 32'h0000_001F;
  localparam word_t TX_ACT_KEEP = 32'hF000_0000;
  localparam word_t RX_ACT_KEEP = 32'hC000_0000;
  localparam word_t SIZE_KEEP   = 32'h0000_00FF;
  localparam word_t PTR_KEEP    = 32'hFFFF_FFFF;

  // status slot k -> address; slot order matches the set-input vector
  function automatic addr_t stat_addr(input int unsigned k);
    case (k)
      0:       return ADR_ERR;
      1:       return ADR_TX_EOB;
      2:       return ADR_TX_DERR;
      3:       return ADR_RX_EOB;
      default: return ADR_RX_DERR;
    endcase
  endfunction
endpackage

// File: rtl/dmr_w1c_reg.sv
module dmr_w1c_reg
  import dmr_pkg::*;
#(
  parameter addr_t ADDR = ADR_ERR
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  bus_req_t req_i,
  input  logic     soft_rst_i,
  input  word_t    set_i,
  output word_t    q_o
);
  logic  sel;
  word_t clr;

  assign sel = req_i.vld && req_i.wr && (req_i.addr == ADDR);
  assign clr = sel ? req_i.wdata : '0;

  // new events win over a clear or soft reset in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         q_o <= '0;
    else if (soft_rst_i) q_o <= set_i;
    else                 q_o <= (q_o & ~clr) | set_i;
  end

  // R4
  set_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

  // R4
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && set_i == '0) |=> ((q_o & $past(req_i.wdata)) == '0));
endmodule

// File: rtl/dmr_fixed_regs.sv
module dmr_fixed_regs
  import dmr_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  bus_req_t                      req_i,
  input  logic [NUM_STAT-1:0][DW-1:0]   set_i,
  output word_t                         rdata_o,
  output logic                          hit_o
);
  logic  wr_en, soft_rst;
  word_t cfg_q, ien_q, tx_set_q, tx_rst_q, rx_set_q, rx_rst_q;
  logic [NUM_STAT-1:0][DW-1:0] stat_q;

  assign wr_en    = req_i.vld && req_i.wr;
  assign soft_rst = wr_en && (req_i.addr == ADR_CFG) && req_i.wdata[SOFT_RST_BIT];

  for (genvar k = 0; k < NUM_STAT; k++) begin : g_stat
    dmr_w1c_reg #(.ADDR(stat_addr(k))) u_stat (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (req_i),
      .soft_rst_i (soft_rst),
      .set_i      (set_i[k]),
      .q_o        (stat_q[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= CFG_INIT;
      ien_q    <= '0;
      tx_set_q <= '0;
      tx_rst_q <= '0;
      rx_set_q <= '0;
      rx_rst_q <= '0;
    end else begin
      if (soft_rst) begin
        ien_q    <= '0;
        tx_set_q <= '0;
        tx_rst_q <= '0;
        rx_set_q <= '0;
        rx_rst_q <= '0;
      end
      if (wr_en) begin
        case (req_i.addr)
          ADR_CFG:    cfg_q    <= req_i.wdata & CFG_KEEP;
          ADR_IEN:    ien_q    <= req_i.wdata & IEN_KEEP;
          ADR_TX_SET: tx_set_q <= req_i.wdata & TX_ACT_KEEP;
          ADR_TX_RST: tx_rst_q <= req_i.wdata & TX_ACT_KEEP;
          ADR_RX_SET: rx_set_q <= req_i.wdata & RX_ACT_KEEP;
          ADR_RX_RST: rx_rst_q <= req_i.wdata & RX_ACT_KEEP;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    hit_o   = 1'b1;
    rdata_o = '0;
    case (req_i.addr)
      ADR_CFG:     rdata_o = cfg_q;
      ADR_ERR:     rdata_o = stat_q[0];
      ADR_IEN:     rdata_o = ien_q;
      ADR_TX_SET:  rdata_o = tx_set_q;
      ADR_TX_RST:  rdata_o = tx_rst_q;
      ADR_TX_EOB:  rdata_o = stat_q[1];
      ADR_TX_DERR: rdata_o = stat_q[2];
      ADR_RX_SET:  rdata_o = rx_set_q;
      ADR_RX_RST:  rdata_o = rx_rst_q;
      ADR_RX_EOB:  rdata_o = stat_q[3];
      ADR_RX_DERR: rdata_o = stat_q[4];
      default:     hit_o   = 1'b0;
    endcase
  end

  // R2
  cfg_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && req_i.addr == ADR_CFG) |=> (cfg_q == ($past(req_i.wdata) & CFG_KEEP)));

  // R3
  soft_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (ien_q == '0 && tx_set_q == '0 && tx_rst_q == '0 &&
                  rx_set_q == '0 && rx_rst_q == '0));

  // R5
  ien_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && req_i.addr == ADR_IEN) |=> (ien_q == ($past(req_i.wdata) & IEN_KEEP)));

  // R6
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> ($stable(tx_set_q) && $stable(tx_rst_q) &&
                $stable(rx_set_q) && $stable(rx_rst_q)));
endmodule

// File: rtl/dmr_chan_bank.sv
module dmr_chan_bank
  import dmr_pkg::*;
#(
  parameter addr_t       BASE  = ADR_TX_PTR,
  parameter int unsigned COUNT = 4,
  parameter word_t       KEEP  = PTR_KEEP
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  bus_req_t req_i,
  output word_t    rdata_o,
  output logic     hit_o
);
  localparam int unsigned LIMIT = int'(BASE) + COUNT;

  logic [AW:0]                addr_x;
  addr_t                      off;
  logic                       wr_hit;
  logic [COUNT-1:0][DW-1:0]   mem_q;

  assign addr_x = {1'b0, req_i.addr};
  assign hit_o  = (addr_x >= {1'b0, BASE}) && (addr_x < (AW+1)'(LIMIT));
  assign off    = req_i.addr - BASE;
  assign wr_hit = req_i.vld && req_i.wr && hit_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else if (wr_hit) begin
      for (int i = 0; i < COUNT; i++) begin
        if (off == addr_t'(i)) mem_q[i] <= req_i.wdata & KEEP;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < COUNT; i++) begin
      if (hit_o && off == addr_t'(i)) rdata_o = mem_q[i];
    end
  end

  // R9
  bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit |=> $stable(mem_q));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dmr_pkg::*;
#(
  parameter int unsigned TX_CH = 4,
  parameter int unsigned RX_CH = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] err_set_i,
  input  logic [DW-1:0] tx_eob_set_i,
  input  logic [DW-1:0] tx_derr_set_i,
  input  logic [DW-1:0] rx_eob_set_i,
  input  logic [DW-1:0] rx_derr_set_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  bus_req_t req;
  logic [NUM_STAT-1:0][DW-1:0] set_vec;
  word_t fix_rd, txp_rd, rxp_rd, rxs_rd;
  logic  fix_hit, txp_hit, rxp_hit, rxs_hit, any_hit, rd_en;

  assign req        = '{vld: req_i, wr: we_i, addr: addr_i, wdata: wdata_i};
  assign set_vec[0] = err_set_i;
  assign set_vec[1] = tx_eob_set_i;
  assign set_vec[2] = tx_derr_set_i;
  assign set_vec[3] = rx_eob_set_i;
  assign set_vec[4] = rx_derr_set_i;
  assign rd_en      = req_i && !we_i;
  assign any_hit    = fix_hit | txp_hit | rxp_hit | rxs_hit;

  dmr_fixed_regs u_fixed (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req),
    .set_i   (set_vec),
    .rdata_o (fix_rd),
    .hit_o   (fix_hit)
  );

  dmr_chan_bank #(.BASE(ADR_TX_PTR), .COUNT(TX_CH), .KEEP(PTR_KEEP)) u_tx_ptr (
    .clk_i (clk_i), .rst_ni (rst_ni), .req_i (req), .rdata_o (txp_rd), .hit_o (txp_hit)
  );

  dmr_chan_bank #(.BASE(ADR_RX_PTR), .COUNT(RX_CH), .KEEP(PTR_KEEP)) u_rx_ptr (
    .clk_i (clk_i), .rst_ni (rst_ni), .req_i (req), .rdata_o (rxp_rd), .hit_o (rxp_hit)
  );

  dmr_chan_bank #(.BASE(ADR_RX_SIZE), .COUNT(RX_CH), .KEEP(SIZE_KEEP)) u_rx_size (
    .clk_i (clk_i), .rst_ni (rst_ni), .req_i (req), .rdata_o (rxs_rd), .hit_o (rxs_hit)
  );

  // banks return zero when not hit, so an OR merge is safe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_en;
      if (rd_en) rdata_o <= fix_rd | txp_rd | rxp_rd | rxs_rd;
    end
  end

  // R10
  rvalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en |=> rvalid_o);

  // R10
  rvalid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en |=> !rvalid_o);

  // R9
  decode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fix_hit, txp_hit, rxp_hit, rxs_hit}));

  // R9
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && !any_hit) |=> (rdata_o == '0));
endmodule

// File: tb/sim_dma_chan_regs.sv
module sim_dma_chan_regs;
  localparam int CLK_PERIOD = 10;
  localparam int TX_N = 4;
  localparam int RX_N = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] err_set = '0, tx_eob_set = '0, tx_derr_set = '0, rx_eob_set = '0, rx_derr_set = '0;
  logic [31:0] rdata;
  logic        rvalid;

  typedef struct {
    logic [9:0]  a;
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_regs #(.TX_CH(TX_N), .RX_CH(RX_N)) u0 (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .we_i (we), .addr_i (addr),
    .wdata_i (wdata), .err_set_i (err_set), .tx_eob_set_i (tx_eob_set),
    .tx_derr_set_i (tx_derr_set), .rx_eob_set_i (rx_eob_set),
    .rx_derr_set_i (rx_derr_set), .rdata_o (rdata), .rvalid_o (rvalid)
  );

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] e, input string t);
    exp_t x;
    x.a = a; x.exp = e; x.tag = t;
    sb_q.push_back(x);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  // monitor: data is due one edge after the read request
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      n_chk++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL R10 unexpected rvalid actual=%h expected=none", rdata);
      end else begin
        exp_t x;
        x = sb_q.pop_front();
        if (rdata !== x.exp) begin
          n_fail++;
          $display("FAIL %s addr=%h actual=%h expected=%h", x.tag, x.a, rdata, x.exp);
        end
      end
    end
  end

  task automatic finish_run();
    if (sb_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R10 missing read data actual=%0d expected=0 pending", sb_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(10'h180, 32'h0007_C000, "R1 cfg");
    rd(10'h181, 32'h0, "R1 err");
    rd(10'h182, 32'h0, "R1 ien");
    rd(10'h184, 32'h0, "R1 txset");
    rd(10'h187, 32'h0, "R1 txderr");
    rd(10'h193, 32'h0, "R1 rxderr");
    rd(10'h1A0, 32'h0, "R1 txptr0");
    rd(10'h1E1, 32'h0, "R1 rxsize1");

    // R2 config mask
    wr(10'h180, 32'h1234_5678);
    rd(10'h180, 32'h0034_4000, "R2 cfg mask");
    wr(10'h180, 32'h7FFF_FFFF);
    rd(10'h180, 32'h00FF_C087, "R2 cfg all");

    // R5 interrupt enable
    wr(10'h182, 32'hFFFF_FFFF);
    rd(10'h182, 32'h0000_001F, "R5 ien");

    // R6 active set/reset
    wr(10'h184, 32'hFFFF_FFFF);
    wr(10'h185, 32'h5FFF_FFFF);
    wr(10'h190, 32'hFFFF_FFFF);
    wr(10'h191, 32'h7FFF_FFFF);
    rd(10'h184, 32'hF000_0000, "R6 txset");
    rd(10'h185, 32'h5000_0000, "R6 txrst");
    rd(10'h190, 32'hC000_0000, "R6 rxset");
    rd(10'h191, 32'h4000_0000, "R6 rxrst");

    // R7 / R8 per-channel windows
    wr(10'h1A0, 32'hDEAD_BEEF);
    wr(10'h1A0 + 10'(TX_N - 1), 32'hA5A5_0001);
    wr(10'h1C1, 32'h1234_5678);
    wr(10'h1E0, 32'hFFFF_FF3C);
    wr(10'h1E1, 32'h0000_01FF);
    rd(10'h1A0, 32'hDEAD_BEEF, "R7 txptr0");
    rd(10'h1A0 + 10'(TX_N - 1), 32'hA5A5_0001, "R7 txptr last");
    rd(10'h1C1, 32'h1234_5678, "R8 rxptr1");
    rd(10'h1E0, 32'h0000_003C, "R8 rxsize0");
    rd(10'h1E1, 32'h0000_00FF, "R8 rxsize1");

    // R9 unmapped: past window ends and gaps
    wr(10'h1A0 + 10'(TX_N), 32'hFFFF_FFFF);
    rd(10'h1A0 + 10'(TX_N), 32'h0, "R9 txptr past end");
    rd(10'h1A0 + 10'(TX_N - 1), 32'hA5A5_0001, "R9 last ptr untouched");
    wr(10'h183, 32'hFFFF_FFFF);
    rd(10'h183, 32'h0, "R9 gap");
    wr(10'h1C0 + 10'(RX_N), 32'h1111_1111);
    rd(10'h1C0 + 10'(RX_N), 32'h0, "R9 rxptr past end");
    rd(10'h1E0 + 10'(RX_N), 32'h0, "R9 rxsize past end");
    rd(10'h182, 32'h0000_001F, "R9 ien untouched");

    // R4 status set and write-one-to-clear
    tx_eob_set = 32'hF000_000F; err_set = 32'h0000_00FF;
    @(negedge clk);
    tx_eob_set = '0; err_set = '0;
    rd(10'h186, 32'hF000_000F, "R4 txeob set");
    rd(10'h181, 32'h0000_00FF, "R4 err set");
    wr(10'h186, 32'h0000_0003);
    wr(10'h181, 32'h0000_000F);
    rd(10'h186, 32'hF000_000C, "R4 txeob w1c");
    rd(10'h181, 32'h0000_00F0, "R4 err w1c");
    rx_derr_set = 32'h0000_0001;
    wr(10'h193, 32'h0000_0001);
    rx_derr_set = '0;
    rd(10'h193, 32'h0000_0001, "R4 set beats clear");
    wr(10'h193, 32'h0000_0001);
    rd(10'h193, 32'h0, "R4 rxderr cleared");
    rx_eob_set = 32'h8000_0000; tx_derr_set = 32'h0000_0100;
    @(negedge clk);
    rx_eob_set = '0; tx_derr_set = '0;
    rd(10'h192, 32'h8000_0000, "R4 rxeob set");
    rd(10'h187, 32'h0000_0100, "R4 txderr set");

    // R3 soft reset
    wr(10'h180, 32'h8000_0001);
    rd(10'h180, 32'h0000_0001, "R3 cfg after soft reset");
    rd(10'h182, 32'h0, "R3 ien");
    rd(10'h184, 32'h0, "R3 txset");
    rd(10'h185, 32'h0, "R3 txrst");
    rd(10'h191, 32'h0, "R3 rxrst");
    rd(10'h181, 32'h0, "R3 err");
    rd(10'h186, 32'h0, "R3 txeob");
    rd(10'h192, 32'h0, "R3 rxeob");
    rd(10'h1A0, 32'hDEAD_BEEF, "R3 txptr kept");
    rd(10'h1E0, 32'h0000_003C, "R3 rxsize kept");

    // R10 back-to-back reads after a write
    wr(10'h1C0, 32'h0BAD_F00D);
    rd(10'h1C0, 32'h0BAD_F00D, "R10 rd after wr");
    rd(10'h1C1, 32'h1234_5678, "R10 back-to-back");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule